// File: doc/BRIEF.md
# Largest-First Gang Issue Scheduler

This block sits beside eight four-lane execution slices and decides, once per clock, which groups of small warps ("gangs") issue in lock step. Every gang slot carries a slice mask naming the slices its member warps occupy, a per-slice ready vector from the slice scoreboards, and an internal instruction-valid flag that a front-end sets when it fills the gang's instruction buffers. The scheduler picks up to two eligible gangs whose slice masks do not overlap, registers their indexes, and clears their instruction-valid flags in the same edge.

Gangs are ranked first by member count, then by a greedy preference for the gang that most recently won the first pick, then by age. Ages form a relative order among the slots; allocating a gang makes it the youngest. Slices that neither chosen gang claims are reported on a registered free mask, so per-slice schedulers can fill them with independent warps.

Top module: `gang_issue_sched`

## Requirements
- R1: A gang is eligible only when its instruction-valid flag is set, its slice mask is nonzero, and every slice bit set in its mask also has its ready bit set.
- R2: At most two gangs are issued per cycle; the first pick is the eligible gang with the largest member count (number of ones in its slice mask), and the second-pick flag is never high without the first.
- R3: Among eligible gangs of equal member count, the gang that was the first pick in the most recent cycle that issued anything is preferred; otherwise the oldest wins.
- R4: After reset the age order has slot 0 oldest and higher indexes younger; asserting alloc_en moves slot alloc_idx to youngest, effective from the next cycle, without changing the relative order of the others.
- R5: The second pick is the best gang, by the same order, among eligible gangs whose slice mask shares no bit with the first pick's mask; if none exists its flag is low.
- R6: free_slices is the bitwise complement of the union of the two chosen masks, all ones when nothing issues.
- R7: Decisions appear on the outputs one cycle after the inputs they are based on; issuing a gang clears its instruction-valid flag, fill_en sets the flag of fill_idx, and a fill wins over an issue of the same slot in the same cycle.
- R8: Synchronous active-high reset clears all instruction-valid flags, both pick flags and indexes (index outputs read 0 whenever their flag is low), and sets free_slices to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_en | input | 1 | Set the instruction-valid flag of one gang slot |
| fill_idx | input | 3 | Slot whose flag is set |
| alloc_en | input | 1 | Mark a slot as newly allocated (youngest) |
| alloc_idx | input | 3 | Slot being allocated |
| gang_mask | input | 8x8 | Per-slot slice membership mask |
| gang_ready | input | 8x8 | Per-slot, per-slice scoreboard ready bits |
| iss0_vld | output | 1 | First pick valid |
| iss0_idx | output | 3 | First pick slot index |
| iss1_vld | output | 1 | Second pick valid |
| iss1_idx | output | 3 | Second pick slot index |
| free_slices | output | 8 | Slices left for per-slice schedulers |

## Verification
The assertions take no promise from the inputs: masks and ready vectors may change every cycle, and a fill may land on a slot in the same cycle it issues, which the flag-clearing property allows for explicitly. The stimulus therefore ranges freely over masks, ready bits, fills and allocations, including empty masks and overlapping gangs, while directed sequences hold ready bits low until several gangs are loaded so that ties, greedy preference and reordered ages are reached deliberately.

// File: rtl/gis_pkg.sv
package gis_pkg;

  parameter int GIS_SLICES = 8;
  parameter int GIS_GANGS  = 8;

  // Ordering key shared by both pick stages: larger gang first,
  // then the greedy slot, then the older slot.
  function automatic logic beats(input int unsigned cnt_a,
                                 input int unsigned cnt_b,
                                 input logic        a_greedy,
                                 input logic        b_greedy,
                                 input logic        a_older);
    if (cnt_a != cnt_b) return cnt_a > cnt_b;
    if (a_greedy)       return 1'b1;
    if (b_greedy)       return 1'b0;
    return a_older;
  endfunction

endpackage

// File: rtl/gis_age_order.sv
module gis_age_order #(
  parameter int NG = gis_pkg::GIS_GANGS,
  localparam int IW = $clog2(NG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   alloc_en,
  input  logic [IW-1:0]          alloc_idx,
  output logic [NG-1:0][NG-1:0]  older  // older[i][j]: slot i older than j
);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NG; i++)
        for (int j = 0; j < NG; j++)
          older[i][j] <= (i < j);
    end else if (alloc_en) begin
      for (int i = 0; i < NG; i++) begin
        older[alloc_idx][i] <= 1'b0;
        if (IW'(i) != alloc_idx) older[i][alloc_idx] <= 1'b1;
      end
    end
  end

  generate
    for (genvar gi = 0; gi < NG; gi++) begin : g_row
      for (genvar gj = gi + 1; gj < NG; gj++) begin : g_col
        p_age_antisym_r4: assert property (@(posedge clk) disable iff (rst)
          older[gi][gj] != older[gj][gi]);
      end
    end
  endgenerate

endmodule

// File: rtl/gis_pick.sv
module gis_pick #(
  parameter int NG = gis_pkg::GIS_GANGS,
  parameter int CW = 4,
  localparam int IW = $clog2(NG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NG-1:0]          elig,
  input  logic [NG-1:0][CW-1:0]  cnt,
  input  logic [NG-1:0][NG-1:0]  older,
  input  logic                   grd_vld,
  input  logic [IW-1:0]          grd_idx,
  output logic                   sel_vld,
  output logic [IW-1:0]          sel_idx
);

  always_comb begin
    sel_vld = 1'b0;
    sel_idx = '0;
    for (int i = 0; i < NG; i++) begin
      if (elig[i] && (!sel_vld ||
          gis_pkg::beats(int'(cnt[i]), int'(cnt[sel_idx]),
                         grd_vld && (grd_idx == IW'(i)),
                         grd_vld && (grd_idx == sel_idx),
                         older[i][sel_idx]))) begin
        sel_vld = 1'b1;
        sel_idx = IW'(i);
      end
    end
  end

  p_sel_is_elig_r1: assert property (@(posedge clk) disable iff (rst)
    sel_vld |-> elig[sel_idx]);
  p_none_when_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (elig == '0) |-> !sel_vld);

endmodule

// File: rtl/gang_issue_sched.sv
module gang_issue_sched #(
  parameter int NG = gis_pkg::GIS_GANGS,
  parameter int NS = gis_pkg::GIS_SLICES,
  localparam int IW = $clog2(NG),
  localparam int CW = $clog2(NS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fill_en,
  input  logic [IW-1:0]         fill_idx,
  input  logic                  alloc_en,
  input  logic [IW-1:0]         alloc_idx,
  input  logic [NG-1:0][NS-1:0] gang_mask,
  input  logic [NG-1:0][NS-1:0] gang_ready,
  output logic                  iss0_vld,
  output logic [IW-1:0]         iss0_idx,
  output logic                  iss1_vld,
  output logic [IW-1:0]         iss1_idx,
  output logic [NS-1:0]         free_slices
);

  logic [NG-1:0]          ibuf_v;
  logic [NG-1:0]          elig0, elig1;
  logic [NG-1:0][CW-1:0]  cnt;
  logic [NG-1:0][NG-1:0]  older;
  logic                   grd_vld;
  logic [IW-1:0]          grd_idx;
  logic                   p0_vld, p1_vld;
  logic [IW-1:0]          p0_idx, p1_idx;
  logic [NS-1:0]          m0, m1;
  logic [NS-1:0]          claim0_q, claim1_q;

  generate
    for (genvar g = 0; g < NG; g++) begin : g_slot
      assign cnt[g]   = CW'($countones(gang_mask[g]));
      assign elig0[g] = ibuf_v[g] && (gang_mask[g] != '0) &&
                        ((gang_mask[g] & ~gang_ready[g]) == '0);
      // a nonzero mask always overlaps itself, so the first pick drops out
      assign elig1[g] = elig0[g] && ((gang_mask[g] & m0) == '0);
    end
  endgenerate

  gis_age_order #(.NG(NG)) u_age (
    .clk(clk), .rst(rst), .alloc_en(alloc_en), .alloc_idx(alloc_idx),
    .older(older)
  );

  gis_pick #(.NG(NG), .CW(CW)) u_pick0 (
    .clk(clk), .rst(rst), .elig(elig0), .cnt(cnt), .older(older),
    .grd_vld(grd_vld), .grd_idx(grd_idx), .sel_vld(p0_vld), .sel_idx(p0_idx)
  );

  assign m0 = p0_vld ? gang_mask[p0_idx] : '0;

  gis_pick #(.NG(NG), .CW(CW)) u_pick1 (
    .clk(clk), .rst(rst), .elig(elig1), .cnt(cnt), .older(older),
    .grd_vld(grd_vld), .grd_idx(grd_idx), .sel_vld(p1_vld), .sel_idx(p1_idx)
  );

  assign m1 = p1_vld ? gang_mask[p1_idx] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ibuf_v   <= '0;
      grd_vld  <= 1'b0;
      grd_idx  <= '0;
      iss0_vld <= 1'b0;
      iss0_idx <= '0;
      iss1_vld <= 1'b0;
      iss1_idx <= '0;
      claim0_q <= '0;
      claim1_q <= '0;
    end else begin
      for (int g = 0; g < NG; g++) begin
        if ((p0_vld && p0_idx == IW'(g)) || (p1_vld && p1_idx == IW'(g)))
          ibuf_v[g] <= 1'b0;
        if (fill_en && fill_idx == IW'(g))
          ibuf_v[g] <= 1'b1;
      end
      if (p0_vld) begin
        grd_vld <= 1'b1;
        grd_idx <= p0_idx;
      end
      iss0_vld <= p0_vld;
      iss0_idx <= p0_idx;
      iss1_vld <= p1_vld;
      iss1_idx <= p1_idx;
      claim0_q <= m0;
      claim1_q <= m1;
    end
  end

  assign free_slices = ~(claim0_q | claim1_q);

  p_pair_disjoint_r5: assert property (@(posedge clk) disable iff (rst)
    (claim0_q & claim1_q) == '0);
  p_second_needs_first_r2: assert property (@(posedge clk) disable iff (rst)
    iss1_vld |-> iss0_vld);
  p_issue_clears_r7: assert property (@(posedge clk) disable iff (rst)
    iss0_vld |-> (!ibuf_v[iss0_idx] ||
                  ($past(fill_en) && $past(fill_idx) == iss0_idx)));
  p_free_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !iss0_vld |-> (free_slices == '1));

endmodule

// File: tb/gang_issue_sched_test.sv
module gang_issue_sched_test;

  localparam int NG = 8;
  localparam int NS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fill_en = 1'b0;
  logic [2:0] fill_idx = '0;
  logic alloc_en = 1'b0;
  logic [2:0] alloc_idx = '0;
  logic [NG-1:0][NS-1:0] gmask = '0;
  logic [NG-1:0][NS-1:0] grdy  = '0;
  logic iss0_vld, iss1_vld;
  logic [2:0] iss0_idx, iss1_idx;
  logic [NS-1:0] free_slices;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gang_issue_sched uut (
    .clk(clk), .rst(rst), .fill_en(fill_en), .fill_idx(fill_idx),
    .alloc_en(alloc_en), .alloc_idx(alloc_idx), .gang_mask(gmask),
    .gang_ready(grdy), .iss0_vld(iss0_vld), .iss0_idx(iss0_idx),
    .iss1_vld(iss1_vld), .iss1_idx(iss1_idx), .free_slices(free_slices)
  );

  // reference state
  bit iv[NG];
  int ageq[$];
  int grd;
  bit grd_v;
  bit e0v, e1v;
  int e0i, e1i;
  int efree;

  function automatic int pos(int a);
    foreach (ageq[k]) if (ageq[k] == a) return k;
    return NG;
  endfunction

  function automatic bit better(int a, int b);
    int ca = $countones(gmask[a]);
    int cb = $countones(gmask[b]);
    if (ca != cb) return ca > cb;
    if (grd_v && a == grd) return 1;
    if (grd_v && b == grd) return 0;
    return pos(a) < pos(b);
  endfunction

  task automatic model_step();
    bit el[NG];
    int p0 = -1;
    int p1 = -1;
    for (int g = 0; g < NG; g++)
      el[g] = iv[g] && gmask[g] != 0 && ((gmask[g] & ~grdy[g]) == 0);
    for (int g = 0; g < NG; g++)
      if (el[g] && (p0 < 0 || better(g, p0))) p0 = g;
    for (int g = 0; g < NG; g++)
      if (el[g] && p0 >= 0 && (gmask[g] & gmask[p0]) == 0 &&
          (p1 < 0 || better(g, p1))) p1 = g;
    e0v = p0 >= 0; e0i = e0v ? p0 : 0;
    e1v = p1 >= 0; e1i = e1v ? p1 : 0;
    efree = 8'hFF;
    if (e0v) efree &= ~int'(gmask[p0]);
    if (e1v) efree &= ~int'(gmask[p1]);
    if (e0v) begin iv[p0] = 0; grd = p0; grd_v = 1; end
    if (e1v) iv[p1] = 0;
    if (fill_en) iv[fill_idx] = 1;
    if (alloc_en) begin
      int k = pos(int'(alloc_idx));
      ageq.delete(k);
      ageq.push_back(int'(alloc_idx));
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R2 iss0_vld"}, int'(iss0_vld), int'(e0v));
    chk({tag, " R2 R3 iss0_idx"}, int'(iss0_idx), e0i);
    chk({tag, " R5 iss1_vld"}, int'(iss1_vld), int'(e1v));
    chk({tag, " R5 iss1_idx"}, int'(iss1_idx), e1i);
    chk({tag, " R6 free_slices"}, int'(free_slices), efree);
  endtask

  task automatic fill(int g);
    fill_en = 1; fill_idx = 3'(g);
    cyc("R7 fill");
    fill_en = 0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int g = 0; g < NG; g++) begin iv[g] = 0; ageq.push_back(g); end
    grd = 0; grd_v = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R8: reset state
    chk("R8 iss0_vld", int'(iss0_vld), 0);
    chk("R8 iss1_vld", int'(iss1_vld), 0);
    chk("R8 free_slices", int'(free_slices), 8'hFF);
    cyc("R8");

    // R1: partial ready and empty mask block issue
    gmask[3] = 8'h0F; grdy[3] = 8'h07;
    gmask[7] = 8'h00; grdy[7] = 8'hFF;
    fill(3); fill(7);
    cyc("R1");
    chk("R1 partial ready", int'(iss0_vld), 0);
    grdy[3] = 8'h0F;
    cyc("R1");
    chk("R1 now ready idx", int'(iss0_idx), 3);

    // R2/R5/R6: largest first, disjoint second pick
    gmask[0] = 8'h03; gmask[1] = 8'hF0; gmask[2] = 8'h0F;
    grdy[0] = 0; grdy[1] = 0; grdy[2] = 0;
    fill(0); fill(1); fill(2);
    grdy[0] = 8'hFF; grdy[1] = 8'hFF; grdy[2] = 8'hFF;
    cyc("R2");
    chk("R2 largest oldest", int'(iss0_idx), 1);
    chk("R5 second pick", int'(iss1_idx), 2);
    chk("R6 none free", int'(free_slices), 8'h00);
    cyc("R2");
    chk("R2 leftover small gang", int'(iss0_idx), 0);
    chk("R6 free after small", int'(free_slices), 8'hFC);

    // R3: greedy preference on a tie
    gmask[4] = 8'h0F; gmask[5] = 8'h0F; grdy[4] = 0; grdy[5] = 8'hFF;
    fill(5);
    cyc("R3");
    chk("R3 slot5 issued", int'(iss0_idx), 5);
    fill(4); fill(5);
    grdy[4] = 8'hFF;
    cyc("R3");
    chk("R3 greedy wins tie", int'(iss0_idx), 5);
    chk("R5 overlap blocks second", int'(iss1_vld), 0);
    cyc("R3");

    // R4: allocation makes a slot youngest
    alloc_en = 1; alloc_idx = 3'd0;
    cyc("R4");
    alloc_en = 0;
    gmask[0] = 8'h33; gmask[6] = 8'h33; grdy[0] = 0; grdy[6] = 0;
    fill(0); fill(6);
    grdy[0] = 8'hFF; grdy[6] = 8'hFF;
    cyc("R4");
    chk("R4 older slot6 first", int'(iss0_idx), 6);
    chk("R6 free with CC", int'(free_slices), 8'hCC);

    // R5 R6 R7: random traffic
    for (int n = 0; n < 3000; n++) begin
      for (int g = 0; g < NG; g++) begin
        if ($urandom_range(3) == 0) gmask[g] = NS'($urandom);
        if ($urandom_range(1) == 0) gmask[g] = NS'(1 << $urandom_range(NS-1));
        grdy[g] = ($urandom_range(3) == 0) ? NS'($urandom) : '1;
      end
      fill_en   = $urandom_range(1) == 1;
      fill_idx  = 3'($urandom);
      alloc_en  = $urandom_range(4) == 0;
      alloc_idx = 3'($urandom);
      cyc("R5 R6 R7 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule